// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave-only endpoint on a two-wire serial bus. It gives an external master read and write access to a small on-chip array of 16-bit words. Addresses are always two bytes and data is always carried as two-byte words. A fast system clock oversamples the bus clock and data lines through a synchronizer. Edges, start conditions and stop conditions are all recognised on the synchronized samples. The block never stretches the bus clock.

A write transfer sends the device byte 0x7A, then the register address (high byte first), then one or more data words (high byte first). A read transfer first writes the two address bytes. It then issues a repeated start with device byte 0x7B and clocks out words, high byte first. The read ends when the master answers a byte with a no-acknowledge. The data line is driven open-drain through a single output-enable pin. There is no valid/ready stream at this edge: the master's bus clock paces every byte, and the slave can apply no back-pressure.

Top module: `twi_reg_slave`

## Requirements
- R1: A falling data line while the clock line is high (start, or repeated start at any point, even mid-byte) restarts device-byte reception. A rising data line while the clock line is high (stop) returns the block to idle with the data line released.
- R2: A first byte of 0x7A (bits [7:1] = 0x3D, bit 0 = 0 for write) or 0x7B (bit 0 = 1 for read) is acknowledged: the slave pulls the data line low during the ninth clock of that byte.
- R3: Any other device byte gets no acknowledge. The slave then neither acknowledges nor stores anything until the next start.
- R4: In a write, the bytes after the device byte are the address high byte, the address low byte, the data high byte and the data low byte, in that order, and each is acknowledged. The register is written only when the data low byte completes, so a transfer stopped after the data high byte changes nothing.
- R5: After each complete written word the register address advances by 2, so further word pairs in the same transfer fill consecutive registers.
- R6: After a write of only the two address bytes, a repeated start with 0x7B makes the slave return the addressed word, high byte first, each byte MSB first.
- R7: In a read, a master acknowledge after a low byte advances the address by 2 and the next word follows. A master no-acknowledge ends the read, and the slave keeps the data line released.
- R8: The output enable sda_oe (1 = pull the line low) changes only while the clock line is low.
- R9: The array holds NREGS words (default 16). The word selected is address bits [4:1]; bit 0 and the bits above 4 are ignored, so address 0x0021 reaches the same word as 0x0000.
- R10: After reset, sda_oe is 0 and every word reads as 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench aims at the moments where a slave most easily loses byte alignment. These are a repeated start in the middle of a byte, a stop right after the data high byte, a foreign device byte followed by a full write-shaped payload, and a read ended by no-acknowledge. A design that ignores the mid-byte restart would shift the later bytes and store a wrong word. A design that commits on the high byte would change a register that must stay unchanged. A design that keeps listening after a mismatch would overwrite a word. A design that keeps driving after the no-acknowledge would hold the line low and corrupt the stop. Random burst writes and reads at arbitrary 16-bit addresses, checked against a bench model, cover carry across the address-advance and aliasing of the word index.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_DEVADR,
    M_WRITE,
    M_READ,
    M_WAIT
  } twi_mode_e;

  typedef enum logic [1:0] {
    W_AHI,
    W_ALO,
    W_DHI,
    W_DLO
  } wr_step_e;

  // After the low data byte the sequence loops back to another data word.
  function automatic wr_step_e next_step(input wr_step_e s);
    unique case (s)
      W_AHI:   return W_ALO;
      W_ALO:   return W_DHI;
      W_DHI:   return W_DLO;
      default: return W_DHI;
    endcase
  endfunction
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NL = 2;

  logic [NL-1:0] raw;
  logic [NL-1:0] last;
  logic [NL-1:0] dly;

  assign raw = {sda_in, scl_in};

  for (genvar l = 0; l < NL; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[l]};
    end
    assign last[l] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly <= '1;
    else        dly <= last;
  end

  assign scl_s     = last[0];
  assign sda_s     = last[1];
  assign scl_rise  = last[0] & ~dly[0];
  assign scl_fall  = ~last[0] & dly[0];
  assign start_det = last[0] & dly[0] & dly[1] & ~last[1];
  assign stop_det  = last[0] & dly[0] & ~dly[1] & last[1];
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int DW    = 16,
  parameter int NREGS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] widx,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREGS)-1:0] ridx,
  output logic [DW-1:0]            rdata
);
  localparam int IW = $clog2(NREGS);

  logic [DW-1:0] mem [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    mem[r] <= '0;
      else if (we && widx == IW'(r)) mem[r] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [6:0] SLV_ADDR = 7'h3D,
  parameter int         AW       = 16,
  parameter int         DW       = 16,
  parameter int         NREGS    = 16,
  parameter int         STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import twi_pkg::*;

  localparam int IDXW = $clog2(NREGS);
  localparam int CW   = 4;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_sync #(.STAGES(STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_mode_e      mode;
  wr_step_e       wr_idx;
  logic [CW-1:0]  bit_cnt;
  logic [7:0]     shreg;
  logic [7:0]     hold;
  logic [AW-1:0]  ptr;
  logic           rw;
  logic           tx_hi;
  logic           wr_en;
  logic [DW-1:0]  wr_word;
  logic [IDXW-1:0] wr_at;
  logic [DW-1:0]  rd_word;
  logic [7:0]     tx_byte;
  logic           active;

  twi_regfile #(.DW(DW), .NREGS(NREGS)) i_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_at), .wdata(wr_word),
    .ridx(ptr[IDXW:1]), .rdata(rd_word)
  );

  assign tx_byte = tx_hi ? rd_word[15:8] : rd_word[7:0];
  assign active  = (mode == M_DEVADR) || (mode == M_WRITE) || (mode == M_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_IDLE;
      wr_idx  <= W_AHI;
      bit_cnt <= '0;
      shreg   <= '0;
      hold    <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      tx_hi   <= 1'b1;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_word <= '0;
      wr_at   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        mode    <= M_DEVADR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        mode   <= M_IDLE;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt < CW'(8)) begin
            shreg <= {shreg[6:0], sda_s};
          end else if (mode == M_READ) begin
            // ninth clock of a sent byte: master acknowledge or not
            if (sda_s) begin
              mode <= M_WAIT;
            end else begin
              tx_hi <= ~tx_hi;
              if (!tx_hi) ptr <= ptr + AW'(2);
            end
          end
        end else if (scl_fall) begin
          if (bit_cnt == CW'(8)) begin
            unique case (mode)
              M_DEVADR: begin
                if (shreg[7:1] == SLV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  mode   <= M_WAIT;
                  sda_oe <= 1'b0;
                end
              end
              M_WRITE: begin
                sda_oe <= 1'b1;
                wr_idx <= next_step(wr_idx);
                unique case (wr_idx)
                  W_AHI: ptr[AW-1:8] <= shreg[AW-9:0];
                  W_ALO: ptr[7:0]    <= shreg;
                  W_DHI: hold        <= shreg;
                  W_DLO: begin
                    wr_en   <= 1'b1;
                    wr_word <= {hold, shreg};
                    wr_at   <= ptr[IDXW:1];
                    ptr     <= ptr + AW'(2);
                  end
                endcase
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bit_cnt == CW'(9)) begin
            bit_cnt <= '0;
            if (mode == M_DEVADR) begin
              mode   <= rw ? M_READ : M_WRITE;
              wr_idx <= W_AHI;
              tx_hi  <= 1'b1;
              sda_oe <= rw & ~rd_word[15];
            end else if (mode == M_READ) begin
              sda_oe <= ~tx_byte[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (mode == M_READ && bit_cnt != '0) begin
            sda_oe <= ~tx_byte[3'd7 - bit_cnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_s,
  input logic                start_det,
  input logic                stop_det,
  input logic                sda_oe,
  input logic                wr_en,
  input logic [3:0]          bit_cnt,
  input twi_pkg::twi_mode_e  mode
);
  import twi_pkg::*;

  // R1
  p_idle_after_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (mode == M_IDLE) && !sda_oe);

  // R1
  p_restart_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (mode == M_DEVADR) && (bit_cnt == 4'd0));

  // R2
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd9);

  // R3
  p_quiet_when_ignoring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WAIT) |-> !sda_oe);

  // R4
  p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8
  p_oe_moves_low_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) && !$past(start_det) && !$past(stop_det) |-> !scl_s);
endmodule

bind twi_reg_slave twi_reg_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en),
  .bit_cnt(bit_cnt), .mode(mode)
);

// File: tb/test_twi_reg_slave.sv
module test_twi_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int WDOG       = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int errors = 0;
  int checks = 0;
  int r8_viol = 0;
  logic oe_prev = 1'b0;
  logic [15:0] mdl [16];
  logic [15:0] wbuf [4];
  logic [15:0] rbuf [4];
  logic oe_after_nack;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_reg_slave i_twi_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    if (rst_n && scl_m && (sda_oe !== oe_prev)) r8_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [3:0] idx_of(input logic [15:0] a);
    return a[4:1];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic clk_bit(input bit b, output bit seen);
    sda_m = b;    waitq();
    scl_m = 1'b1; waitq();
    seen = sda_line; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(nack, s);
  endtask

  task automatic wr_burst(input logic [15:0] a, input int n, output int nacks);
    bit ack;
    nacks = 0;
    bus_start();
    put_byte(8'h7A, ack);   if (!ack) nacks++;
    put_byte(a[15:8], ack); if (!ack) nacks++;
    put_byte(a[7:0], ack);  if (!ack) nacks++;
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k][15:8], ack); if (!ack) nacks++;
      put_byte(wbuf[k][7:0], ack);  if (!ack) nacks++;
    end
    bus_stop();
  endtask

  task automatic rd_burst(input logic [15:0] a, input int n, output int nacks);
    bit ack;
    logic [7:0] hi, lo;
    nacks = 0;
    bus_start();
    put_byte(8'h7A, ack);   if (!ack) nacks++;
    put_byte(a[15:8], ack); if (!ack) nacks++;
    put_byte(a[7:0], ack);  if (!ack) nacks++;
    bus_start();
    put_byte(8'h7B, ack);   if (!ack) nacks++;
    for (int k = 0; k < n; k++) begin
      get_byte(1'b0, hi);
      get_byte(k == n - 1, lo);
      rbuf[k] = {hi, lo};
    end
    oe_after_nack = sda_oe;
    bus_stop();
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", WDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int nk;
    int seedv;
    bit ack;
    bit s;
    for (int i = 0; i < 16; i++) mdl[i] = 16'h0000;
    seedv = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: word reads zero after reset
    rd_burst(16'h0002, 1, nk);
    chk(rbuf[0] == 16'h0000, "R10 reset word", 32'(rbuf[0]), 0);
    chk(oe_after_nack == 1'b0, "R7 release after nack", 32'(oe_after_nack), 0);

    // R2 R4: simple write, all bytes acknowledged
    wbuf[0] = 16'h1234;
    wr_burst(16'h0004, 1, nk);
    mdl[idx_of(16'h0004)] = 16'h1234;
    chk(nk == 0, "R2 R4 acks on write", 32'(nk), 0);
    rd_burst(16'h0004, 1, nk);
    chk(nk == 0, "R2 acks on read setup", 32'(nk), 0);
    chk(rbuf[0] == 16'h1234, "R6 read back", 32'(rbuf[0]), 32'h1234);

    // R3: foreign device byte, payload ignored
    bus_start();
    put_byte(8'h7C, ack);
    chk(!ack, "R3 mismatch nack", 32'(ack), 0);
    nk = 0;
    put_byte(8'h00, ack); if (ack) nk++;
    put_byte(8'h04, ack); if (ack) nk++;
    put_byte(8'hFF, ack); if (ack) nk++;
    put_byte(8'hFF, ack); if (ack) nk++;
    bus_stop();
    chk(nk == 0, "R3 no ack while ignoring", 32'(nk), 0);
    rd_burst(16'h0004, 1, nk);
    chk(rbuf[0] == 16'h1234, "R3 word untouched", 32'(rbuf[0]), 32'h1234);

    // R4: stop after data high byte commits nothing
    bus_start();
    put_byte(8'h7A, ack);
    put_byte(8'h00, ack);
    put_byte(8'h06, ack);
    put_byte(8'hAB, ack);
    bus_stop();
    rd_burst(16'h0006, 1, nk);
    chk(rbuf[0] == 16'h0000, "R4 partial write", 32'(rbuf[0]), 0);

    // R1: repeated start in the middle of a byte
    bus_start();
    put_byte(8'h7A, ack);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    wbuf[0] = 16'hBEEF;
    wr_burst(16'h000C, 1, nk);
    mdl[idx_of(16'h000C)] = 16'hBEEF;
    chk(nk == 0, "R1 acks after restart", 32'(nk), 0);
    chk(sda_oe == 1'b0, "R1 released after stop", 32'(sda_oe), 0);
    rd_burst(16'h000C, 1, nk);
    chk(rbuf[0] == 16'hBEEF, "R1 word after restart", 32'(rbuf[0]), 32'hBEEF);

    // R5: burst write, then single reads
    wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h3333;
    wr_burst(16'h0008, 3, nk);
    for (int k = 0; k < 3; k++) mdl[idx_of(16'h0008 + 16'(2*k))] = wbuf[k];
    for (int k = 0; k < 3; k++) begin
      rd_burst(16'h0008 + 16'(2*k), 1, nk);
      chk(rbuf[0] == mdl[idx_of(16'h0008 + 16'(2*k))], "R5 burst write",
          32'(rbuf[0]), 32'(mdl[idx_of(16'h0008 + 16'(2*k))]));
    end

    // R7: burst read with release after no-acknowledge
    rd_burst(16'h0008, 3, nk);
    for (int k = 0; k < 3; k++)
      chk(rbuf[k] == mdl[idx_of(16'h0008 + 16'(2*k))], "R7 burst read",
          32'(rbuf[k]), 32'(mdl[idx_of(16'h0008 + 16'(2*k))]));
    chk(oe_after_nack == 1'b0, "R7 release after burst", 32'(oe_after_nack), 0);

    // R9: aliasing of the word index
    wbuf[0] = 16'h5A5A;
    wr_burst(16'h0021, 1, nk);
    mdl[idx_of(16'h0021)] = 16'h5A5A;
    rd_burst(16'h0000, 1, nk);
    chk(rbuf[0] == 16'h5A5A, "R9 alias", 32'(rbuf[0]), 32'h5A5A);

    // R5 R6 R7 R9: random bursts against the model
    for (int it = 0; it < 14; it++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) begin
        wbuf[k] = 16'($urandom);
        mdl[idx_of(a + 16'(2*k))] = wbuf[k];
      end
      wr_burst(a, n, nk);
      chk(nk == 0, "R5 random write acks", 32'(nk), 0);
      rd_burst(a, n, nk);
      for (int k = 0; k < n; k++)
        chk(rbuf[k] == mdl[idx_of(a + 16'(2*k))], "R6 R7 R9 random read",
            32'(rbuf[k]), 32'(mdl[idx_of(a + 16'(2*k))]));
    end

    chk(r8_viol == 0, "R8 oe steady while clock high", 32'(r8_viol), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule